// File: doc/BRIEF.md
# PWM Output Safe-State Override

This stage sits between a complementary PWM pair generator and the output pins of one submodule. It handles two outputs, the main channel B and the auxiliary channel X. While a fault is flagged, or while the chip is in a low-power or debug condition that is not allowed to keep the PWM running, each output is replaced by a safe state. Each channel has its own 2-bit code for that safe state: drive low, drive high, or release the pin.

A forced level is injected before the per-channel polarity inversion, so an inverted channel drives the complement of the programmed level. The release codes only drop the output-enable. In that case the registered pin value keeps what it last held, whatever the polarity setting. The override decision is combinational from the mode and fault inputs. Both pin values and both enables are registered, so a change at the inputs shows at the ports after the next rising clock edge. Reset clears the registers so that both outputs are released.

Top module: `pwm_safe_override`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first rising edge, `oe_b` and `oe_x` are 0 and `pin_b` and `pin_x` are 0.
- R2: With no override condition, after a rising edge each channel has its enable at 1 and its pin at the raw PWM input XOR its invert bit, both sampled at that edge.
- R3: While `fault_act` is 1 the override applies. A safe code of 2'b00 yields level 0 and 2'b01 yields level 1, before polarity.
- R4: The forced level passes through polarity: with the invert bit at 1, code 2'b00 drives the pin to 1 and code 2'b01 drives it to 0, with the enable at 1.
- R5: Under override, a safe code with bit 1 set (2'b10 or 2'b11) drives the enable to 0 and leaves the pin register at its previous value, for either invert setting.
- R6: `stop_mode` at 1 always applies the override, whatever the run-enable bits are.
- R7: `wait_mode` at 1 applies the override when `wait_run_en` is 0. When `wait_run_en` is 1 the raw PWM passes through, provided no other condition holds.
- R8: `dbg_mode` at 1 applies the override when `dbg_run_en` is 0. When `dbg_run_en` is 1 the raw PWM passes through, provided no other condition holds.
- R9: The two channels are independent. Each uses only its own safe code, invert bit and PWM input, and they share the override decision.
- R10: Outputs change only at a rising clock edge. An input change between edges does not alter the ports until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_b_in | input | 1 | Raw PWM for channel B |
| pwm_x_in | input | 1 | Raw PWM for channel X |
| fault_act | input | 1 | Fault condition active |
| stop_mode | input | 1 | Stop mode indicator |
| wait_mode | input | 1 | Wait mode indicator |
| dbg_mode | input | 1 | Debug mode indicator |
| wait_run_en | input | 1 | 1 lets the PWM run during wait mode |
| dbg_run_en | input | 1 | 1 lets the PWM run during debug mode |
| safe_b | input | 2 | Safe-state code for channel B (00 low, 01 high, 1x release) |
| safe_x | input | 2 | Safe-state code for channel X (00 low, 01 high, 1x release) |
| inv_b | input | 1 | Polarity invert for channel B |
| inv_x | input | 1 | Polarity invert for channel X |
| pin_b | output | 1 | Registered pin value, channel B |
| oe_b | output | 1 | Registered output-enable, channel B |
| pin_x | output | 1 | Registered pin value, channel X |
| oe_x | output | 1 | Registered output-enable, channel X |

## Verification
A wrong override decision shows one clock after the offending inputs. A channel keeps following its raw PWM while it should be forced, or it drops to its safe level while it should run. A fault in the code decode or polarity path appears at that same edge as a complemented pin or a wrongly set enable. A broken hold path appears only when a release code follows a driven state: the pin register changes while its enable is low.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    SAFE_LOW  = 2'b00,
    SAFE_HIGH = 2'b01,
    SAFE_REL0 = 2'b10,
    SAFE_REL1 = 2'b11
  } safe_code_e;

  // Decision to replace the PWM by the safe state.
  function automatic logic f_override_req(
    input logic fault, input logic stop,
    input logic wt, input logic wt_run,
    input logic dbg, input logic dbg_run);
    return fault | stop | (wt & ~wt_run) | (dbg & ~dbg_run);
  endfunction

  // Release codes have the upper bit set.
  function automatic logic f_is_release(input logic [CODE_W-1:0] code);
    return code[CODE_W-1];
  endfunction

  // Forced level, before polarity.
  function automatic logic f_forced_level(input logic [CODE_W-1:0] code);
    return (code == SAFE_HIGH);
  endfunction

  function automatic logic f_apply_pol(input logic lvl, input logic inv);
    return lvl ^ inv;
  endfunction

endpackage

// File: rtl/pwm_ovr_mode_gate.sv
module pwm_ovr_mode_gate
  import pwm_ovr_pkg::*;
(
  input  logic fault_act,
  input  logic stop_mode,
  input  logic wait_mode,
  input  logic dbg_mode,
  input  logic wait_run_en,
  input  logic dbg_run_en,
  output logic ovr_req
);

  always_comb begin
    ovr_req = f_override_req(fault_act, stop_mode, wait_mode, wait_run_en,
                             dbg_mode, dbg_run_en);
  end

endmodule

// File: rtl/pwm_ovr_chan.sv
module pwm_ovr_chan
  import pwm_ovr_pkg::*;
(
  input  logic              pwm_raw,
  input  logic [CODE_W-1:0] safe_code,
  input  logic              inv,
  input  logic              ovr_req,
  output logic              nxt_pin,
  output logic              nxt_oe,
  output logic              hold_pin
);

  logic pre_pol;
  logic rel;

  always_comb begin
    rel      = ovr_req & f_is_release(safe_code);
    pre_pol  = ovr_req ? f_forced_level(safe_code) : pwm_raw;
    nxt_pin  = f_apply_pol(pre_pol, inv);
    nxt_oe   = ~rel;
    hold_pin = rel;
  end

endmodule

// File: rtl/pwm_ovr_outreg.sv
module pwm_ovr_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic nxt_pin,
  input  logic nxt_oe,
  input  logic hold_pin,
  output logic pin_q,
  output logic oe_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= nxt_oe;
      if (!hold_pin) pin_q <= nxt_pin;
    end
  end

endmodule

// File: rtl/pwm_safe_override.sv
module pwm_safe_override
  import pwm_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_b_in,
  input  logic              pwm_x_in,
  input  logic              fault_act,
  input  logic              stop_mode,
  input  logic              wait_mode,
  input  logic              dbg_mode,
  input  logic              wait_run_en,
  input  logic              dbg_run_en,
  input  logic [CODE_W-1:0] safe_b,
  input  logic [CODE_W-1:0] safe_x,
  input  logic              inv_b,
  input  logic              inv_x,
  output logic              pin_b,
  output logic              oe_b,
  output logic              pin_x,
  output logic              oe_x
);

  localparam int NCH = 2;
  localparam int CH_B = 0;
  localparam int CH_X = 1;

  // Named internal event for the checker.
  logic ovr_req;

  logic [NCH-1:0]             raw_v;
  logic [NCH-1:0]             inv_v;
  logic [NCH-1:0][CODE_W-1:0] code_v;
  logic [NCH-1:0]             nxt_pin_v;
  logic [NCH-1:0]             nxt_oe_v;
  logic [NCH-1:0]             hold_v;
  logic [NCH-1:0]             pin_v;
  logic [NCH-1:0]             oe_v;

  always_comb begin
    raw_v[CH_B]  = pwm_b_in;
    raw_v[CH_X]  = pwm_x_in;
    inv_v[CH_B]  = inv_b;
    inv_v[CH_X]  = inv_x;
    code_v[CH_B] = safe_b;
    code_v[CH_X] = safe_x;
  end

  pwm_ovr_mode_gate u_gate (
    .fault_act   (fault_act),
    .stop_mode   (stop_mode),
    .wait_mode   (wait_mode),
    .dbg_mode    (dbg_mode),
    .wait_run_en (wait_run_en),
    .dbg_run_en  (dbg_run_en),
    .ovr_req     (ovr_req)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_ovr_chan u_chan (
      .pwm_raw   (raw_v[c]),
      .safe_code (code_v[c]),
      .inv       (inv_v[c]),
      .ovr_req   (ovr_req),
      .nxt_pin   (nxt_pin_v[c]),
      .nxt_oe    (nxt_oe_v[c]),
      .hold_pin  (hold_v[c])
    );

    pwm_ovr_outreg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_pin  (nxt_pin_v[c]),
      .nxt_oe   (nxt_oe_v[c]),
      .hold_pin (hold_v[c]),
      .pin_q    (pin_v[c]),
      .oe_q     (oe_v[c])
    );
  end

  assign pin_b = pin_v[CH_B];
  assign oe_b  = oe_v[CH_B];
  assign pin_x = pin_v[CH_X];
  assign oe_x  = oe_v[CH_X];

endmodule

// File: rtl/pwm_ovr_chk.sv
module pwm_ovr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_b_in,
  input logic       pwm_x_in,
  input logic       stop_mode,
  input logic       wait_mode,
  input logic       dbg_mode,
  input logic       wait_run_en,
  input logic       dbg_run_en,
  input logic [1:0] safe_b,
  input logic [1:0] safe_x,
  input logic       inv_b,
  input logic       inv_x,
  input logic       pin_b,
  input logic       oe_b,
  input logic       pin_x,
  input logic       oe_x,
  input logic       ovr_req
);

  a_r1_reset_released: assert property (@(posedge clk)
    !rst_n |=> (!oe_b && !oe_x && !pin_b && !pin_x));

  a_r2_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_req |=> (oe_b && pin_b == $past(pwm_b_in ^ inv_b)));

  a_r2_pass_x: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_req |=> (oe_x && pin_x == $past(pwm_x_in ^ inv_x)));

  a_r4_force_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_req && !safe_b[1]) |=> (oe_b && pin_b == $past(safe_b[0] ^ inv_b)));

  a_r4_force_x: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_req && !safe_x[1]) |=> (oe_x && pin_x == $past(safe_x[0] ^ inv_x)));

  a_r5_release_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_req && safe_b[1]) |=> (!oe_b && $stable(pin_b)));

  a_r5_release_x: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_req && safe_x[1]) |=> (!oe_x && $stable(pin_x)));

  a_r6_stop_forces: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> ovr_req);

  a_r7_wait_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && !wait_run_en) |-> ovr_req);

  a_r8_dbg_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !dbg_run_en) |-> ovr_req);

endmodule

bind pwm_safe_override pwm_ovr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_b_in    (pwm_b_in),
  .pwm_x_in    (pwm_x_in),
  .stop_mode   (stop_mode),
  .wait_mode   (wait_mode),
  .dbg_mode    (dbg_mode),
  .wait_run_en (wait_run_en),
  .dbg_run_en  (dbg_run_en),
  .safe_b      (safe_b),
  .safe_x      (safe_x),
  .inv_b       (inv_b),
  .inv_x       (inv_x),
  .pin_b       (pin_b),
  .oe_b        (oe_b),
  .pin_x       (pin_x),
  .oe_x        (oe_x),
  .ovr_req     (ovr_req)
);

// File: tb/pwm_safe_override_tb.sv
module pwm_safe_override_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_b_in = 0, pwm_x_in = 0, fault_act = 0, stop_mode = 0;
  logic wait_mode = 0, dbg_mode = 0, wait_run_en = 0, dbg_run_en = 0;
  logic [1:0] safe_b = 2'b00, safe_x = 2'b00;
  logic inv_b = 0, inv_x = 0;
  logic pin_b, oe_b, pin_x, oe_x;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_safe_override u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_b_in(pwm_b_in), .pwm_x_in(pwm_x_in),
    .fault_act(fault_act), .stop_mode(stop_mode), .wait_mode(wait_mode),
    .dbg_mode(dbg_mode), .wait_run_en(wait_run_en), .dbg_run_en(dbg_run_en),
    .safe_b(safe_b), .safe_x(safe_x), .inv_b(inv_b), .inv_x(inv_x),
    .pin_b(pin_b), .oe_b(oe_b), .pin_x(pin_x), .oe_x(oe_x)
  );

  // Vector: tag | pb px f s w d we de | sb sx | ib ix | oeb pb oex px
  localparam int VW = 4 + 8 + 4 + 2 + 4;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  8'b10000000, 4'b0000, 2'b00, 4'b1110},  // R2 plain pass
    {4'd2,  8'b10000000, 4'b0000, 2'b01, 4'b1111},  // R2 invert on X
    {4'd3,  8'b10100000, 4'b0001, 2'b00, 4'b1011},  // R3 fault 00/01
    {4'd4,  8'b10100000, 4'b0001, 2'b11, 4'b1110},  // R4 inverted forced
    {4'd5,  8'b10100000, 4'b1011, 2'b11, 4'b0100},  // R5 release, hold
    {4'd5,  8'b10100000, 4'b1011, 2'b00, 4'b0100},  // R5 polarity ignored
    {4'd6,  8'b01010011, 4'b0100, 2'b00, 4'b1110},  // R6 stop with enables
    {4'd7,  8'b10001000, 4'b0001, 2'b00, 4'b1011},  // R7 wait, no run
    {4'd7,  8'b10001010, 4'b0001, 2'b00, 4'b1110},  // R7 wait, run
    {4'd8,  8'b01000100, 4'b0100, 2'b00, 4'b1110},  // R8 debug, no run
    {4'd8,  8'b01000101, 4'b0100, 2'b00, 4'b1011},  // R8 debug, run
    {4'd9,  8'b00100000, 4'b1001, 2'b01, 4'b0010},  // R9 mixed channels
    {4'd7,  8'b11001101, 4'b0000, 2'b00, 4'b1010},  // R7 wait wins over dbg run
    {4'd2,  8'b01000000, 4'b0000, 2'b00, 4'b1011}   // R2 back to normal
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe_b,pin_b,oe_x,pin_x} actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [VW-1:0] v;
    // R1: reset state before any edge, and while held
    #1;
    check("R1", {oe_b, pin_b, oe_x, pin_x}, 4'b0000);
    repeat (3) @(negedge clk);
    check("R1", {oe_b, pin_b, oe_x, pin_x}, 4'b0000);
    rst_n = 1'b1;
    #1;
    check("R1", {oe_b, pin_b, oe_x, pin_x}, 4'b0000);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      {pwm_b_in, pwm_x_in, fault_act, stop_mode, wait_mode, dbg_mode,
       wait_run_en, dbg_run_en} = v[17:10];
      {safe_b, safe_x} = v[9:6];
      {inv_b, inv_x} = v[5:4];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", v[21:18], i), {oe_b, pin_b, oe_x, pin_x}, v[3:0]);
    end

    // R10: outputs hold between edges, then follow at the edge
    {fault_act, stop_mode, wait_mode, dbg_mode} = 4'b0000;
    {inv_b, inv_x} = 2'b00;
    pwm_b_in = 1'b1; pwm_x_in = 1'b0;
    #1;
    check("R10", {oe_b, pin_b, oe_x, pin_x}, 4'b1011);
    @(negedge clk);
    check("R10", {oe_b, pin_b, oe_x, pin_x}, 4'b1110);

    // R5: release after a driven 1 keeps pin at 1 for several cycles
    fault_act = 1'b1; safe_b = 2'b11; safe_x = 2'b10; pwm_b_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5", {oe_b, pin_b, oe_x, pin_x}, 4'b0100);

    // R6: stop overrides while both run enables are on and fault is off
    fault_act = 1'b0; stop_mode = 1'b1; wait_run_en = 1'b1; dbg_run_en = 1'b1;
    safe_b = 2'b00; safe_x = 2'b01; inv_b = 1'b0; inv_x = 1'b0;
    pwm_b_in = 1'b1; pwm_x_in = 1'b0;
    @(negedge clk);
    check("R6", {oe_b, pin_b, oe_x, pin_x}, 4'b1011);

    // R1: asynchronous reset mid-run releases outputs at once
    rst_n = 1'b0;
    #1;
    check("R1", {oe_b, pin_b, oe_x, pin_x}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 still active after reset release: forced levels again
    check("R6", {oe_b, pin_b, oe_x, pin_x}, 4'b1011);

    done = 1'b1;
    finish_run();
  end

endmodule